// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides who owns the local bus: the chip's own bus unit, or an external master that asks for the bus with a hold request. It answers with a hold acknowledge. Before that acknowledge rises, it floats the shared bus and strobe outputs and forces every chip select high. It also gives a grant to the internal DRAM refresh logic, which always wins over the external master.

The external request is brought into the clock domain through a synchronizer whose depth is a parameter. Once synchronized, the request waits for two things: the internal bus cycle in progress must finish, and any locked transfer must end. A refresh request that arrives while the bus is held takes the bus back. The acknowledge falls first and the float is removed one clock later. The external master then has to wait until the refresh logic withdraws its request.

Top module: `bus_hold_arb`

## Requirements
- R1: After reset, hold_ack, bus_float, cs_force_high and refresh_grant are all low.
- R2: While cyc_active is high, bus_float stays low. Once cyc_active falls, bus_float rises on the next clock edge.
- R3: While lock_active is high, a pending hold request is not granted and bus_float stays low. The grant proceeds once the lock ends.
- R4: bus_float and cs_force_high rise together, one clock before hold_ack rises, and cs_force_high always equals bus_float.
- R5: When hold_req falls, hold_ack falls SYNC_STAGES+1 edges later. bus_float falls one edge after hold_ack.
- R6: If refresh_req rises while hold_ack is high, hold_ack falls on the next edge even though hold_req is still high. bus_float falls one edge after that and refresh_grant rises.
- R7: When refresh_req and hold_req rise in the same cycle, refresh_grant rises at once (combinationally). The hold is not granted while refresh_req stays high.
- R8: After a refresh pre-emption, hold_ack stays low as long as refresh_req is high. It returns three edges after refresh_req falls, with bus_float leading by one edge.
- R9: A hold request withdrawn before the grant leaves bus_float and hold_ack low.
- R10: From an idle bus, bus_float rises SYNC_STAGES+2 edges after hold_req rises, and hold_ack rises one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req | input | 1 | Asynchronous bus request from the external master |
| cyc_active | input | 1 | An internal bus cycle is in progress |
| lock_active | input | 1 | A locked transfer is in progress |
| refresh_req | input | 1 | Internal DRAM refresh needs the bus |
| hold_ack | output | 1 | Bus handed to the external master |
| bus_float | output | 1 | Float the address, data, strobe and status outputs |
| cs_force_high | output | 1 | Drive all chip selects inactive-high |
| refresh_grant | output | 1 | Bus granted to the refresh logic |

## Verification
The checker watches a set of rules on every cycle. The acknowledge never stands without the float, and the float never coincides with a refresh grant. The float rises one clock ahead of the acknowledge and falls only after it. The bus is released only after a cycle with no bus activity, no lock and no refresh. A pending refresh removes the acknowledge on the next edge. Exact latencies can only be shown by the bench's directed scenarios: how long a lock or a bus cycle stretches the wait, whether a hold is re-granted once the refresh ends, and whether a simultaneous request is deferred or a withdrawn one is ignored.

// File: rtl/bha_pkg.sv
// Package: shared state encoding for the bus hold arbiter.
// Assumes: used by the FSM, decode and checker of bus_hold_arb only.
package bha_pkg;
    typedef enum logic [2:0] {
        ST_OWN     = 3'd0,  // internal bus unit owns the bus
        ST_DRAIN   = 3'd1,  // hold pending, waiting for cycle/lock to end
        ST_RELEASE = 3'd2,  // outputs floated, acknowledge not yet given
        ST_HELD    = 3'd3,  // external master owns the bus
        ST_RECLAIM = 3'd4   // acknowledge dropped, outputs still floated
    } arb_state_t;
endpackage

// File: rtl/bha_sync.sv
// Module: bha_sync
// Brings one asynchronous level into the clock domain through a chain of
// STAGES flops. Assumes STAGES >= 1 and a level held far longer than STAGES.
module bha_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // single flop capture
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            // shift the level through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bha_fsm.sv
// Module: bha_fsm
// Ownership sequencer. Refresh beats hold; hold waits out a bus cycle and a
// lock; the float precedes the acknowledge by one clock on the way out, and
// the acknowledge precedes the float on the way back.
// Assumes hold_s is already synchronous.
module bha_fsm
    import bha_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_s,
    input  logic       cyc_active,
    input  logic       lock_active,
    input  logic       refresh_req,
    output arb_state_t state
);
    arb_state_t nxt;
    logic       bus_quiet;

    assign bus_quiet = !cyc_active && !lock_active;

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OWN:     if (hold_s && !refresh_req) nxt = ST_DRAIN;
            ST_DRAIN:   if (refresh_req || !hold_s) nxt = ST_OWN;
                        else if (bus_quiet)         nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_HELD;
            ST_HELD:    if (refresh_req || !hold_s) nxt = ST_RECLAIM;
            ST_RECLAIM: nxt = ST_OWN;
            default:    nxt = ST_OWN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OWN;
        else        state <= nxt;
    end
endmodule

// File: rtl/bha_decode.sv
// Module: bha_decode
// Turns the sequencer state into the pad-control and grant outputs.
// Assumes state is registered, so the outputs are free of glitches apart
// from refresh_grant, which follows refresh_req while the bus is owned.
module bha_decode
    import bha_pkg::*;
(
    input  arb_state_t state,
    input  logic       refresh_req,
    output logic       hold_ack,
    output logic       bus_float,
    output logic       cs_force_high,
    output logic       refresh_grant
);
    // output decode
    always_comb begin
        bus_float     = (state == ST_RELEASE) || (state == ST_HELD) ||
                        (state == ST_RECLAIM);
        hold_ack      = (state == ST_HELD);
        cs_force_high = bus_float;
        refresh_grant = refresh_req &&
                        ((state == ST_OWN) || (state == ST_DRAIN));
    end
endmodule

// File: rtl/bus_hold_arb.sv
// Module: bus_hold_arb
// Top of the bus hold arbiter: synchronizer, sequencer and output decode.
// Assumes cyc_active, lock_active and refresh_req are synchronous to clk.
module bus_hold_arb #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic cyc_active,
    input  logic lock_active,
    input  logic refresh_req,
    output logic hold_ack,
    output logic bus_float,
    output logic cs_force_high,
    output logic refresh_grant
);
    import bha_pkg::*;

    logic       hold_s;
    arb_state_t state;

    bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(hold_req), .q(hold_s)
    );

    bha_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hold_s(hold_s),
        .cyc_active(cyc_active), .lock_active(lock_active),
        .refresh_req(refresh_req), .state(state)
    );

    bha_decode u_dec (
        .state(state), .refresh_req(refresh_req),
        .hold_ack(hold_ack), .bus_float(bus_float),
        .cs_force_high(cs_force_high), .refresh_grant(refresh_grant)
    );
endmodule

// File: rtl/bus_hold_arb_chk.sv
// Module: bus_hold_arb_chk
// Cycle-level rules for bus_hold_arb, bound to every instance of it.
module bus_hold_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_active,
    input logic lock_active,
    input logic refresh_req,
    input logic hold_ack,
    input logic bus_float,
    input logic cs_force_high,
    input logic refresh_grant
);
    // R4
    ack_needs_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> bus_float);
    // R4
    cs_follows_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_force_high == bus_float);
    // R4
    float_leads_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(bus_float));
    // R5
    ack_leads_unfloat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_float) |-> !$past(hold_ack));
    // R2
    release_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_float) |-> $past(!cyc_active && !lock_active && !refresh_req));
    // R6
    preempt_drops_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && refresh_req) |=> !hold_ack);
    // R7
    grant_not_floated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_grant |-> !bus_float);
endmodule

bind bus_hold_arb bus_hold_arb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_active(cyc_active),
    .lock_active(lock_active), .refresh_req(refresh_req),
    .hold_ack(hold_ack), .bus_float(bus_float),
    .cs_force_high(cs_force_high), .refresh_grant(refresh_grant)
);

// File: tb/bus_hold_arb_tb.sv
// Directed bench for bus_hold_arb: one task per scenario.
module bus_hold_arb_tb_top;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req = 1'b0, cyc_active = 1'b0, lock_active = 1'b0, refresh_req = 1'b0;
    logic hold_ack, bus_float, cs_force_high, refresh_grant;
    int   n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    bus_hold_arb #(.SYNC_STAGES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req),
        .cyc_active(cyc_active), .lock_active(lock_active),
        .refresh_req(refresh_req), .hold_ack(hold_ack),
        .bus_float(bus_float), .cs_force_high(cs_force_high),
        .refresh_grant(refresh_grant)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic go_idle();
        hold_req = 0; refresh_req = 0; cyc_active = 0; lock_active = 0;
        step(S + 3);
    endtask

    task automatic t_reset();
        step(3);
        chk("R1", "hold_ack", hold_ack, 1'b0);
        chk("R1", "bus_float", bus_float, 1'b0);
        chk("R1", "cs_force_high", cs_force_high, 1'b0);
        chk("R1", "refresh_grant", refresh_grant, 1'b0);
        rst_n = 1;
        step(1);
    endtask

    task automatic t_latency();
        hold_req = 1;
        step(S + 1);
        chk("R10", "float before latency", bus_float, 1'b0);
        step(1);
        chk("R10", "float at latency", bus_float, 1'b1);
        chk("R4", "cs with float", cs_force_high, 1'b1);
        chk("R4", "ack one clock late", hold_ack, 1'b0);
        step(1);
        chk("R10", "ack", hold_ack, 1'b1);
        hold_req = 0;
        step(S + 1);
        chk("R5", "ack dropped", hold_ack, 1'b0);
        chk("R5", "float still on", bus_float, 1'b1);
        step(1);
        chk("R5", "float dropped", bus_float, 1'b0);
        chk("R5", "cs released", cs_force_high, 1'b0);
        go_idle();
    endtask

    task automatic t_cycle();
        cyc_active = 1; hold_req = 1;
        step(S + 6);
        chk("R2", "float during cycle", bus_float, 1'b0);
        cyc_active = 0;
        step(1);
        chk("R2", "float after cycle", bus_float, 1'b1);
        step(1);
        chk("R2", "ack after cycle", hold_ack, 1'b1);
        go_idle();
    endtask

    task automatic t_lock();
        lock_active = 1; hold_req = 1;
        step(S + 10);
        chk("R3", "float during lock", bus_float, 1'b0);
        chk("R3", "ack during lock", hold_ack, 1'b0);
        lock_active = 0;
        step(1);
        chk("R3", "float after lock", bus_float, 1'b1);
        step(1);
        chk("R3", "ack after lock", hold_ack, 1'b1);
        go_idle();
    endtask

    task automatic t_preempt();
        hold_req = 1;
        step(S + 3);
        chk("R6", "held before refresh", hold_ack, 1'b1);
        refresh_req = 1;
        step(1);
        chk("R6", "ack dropped by refresh", hold_ack, 1'b0);
        chk("R6", "float kept", bus_float, 1'b1);
        step(1);
        chk("R6", "float dropped", bus_float, 1'b0);
        chk("R6", "refresh granted", refresh_grant, 1'b1);
        step(6);
        chk("R8", "no regrant during refresh", hold_ack, 1'b0);
        chk("R8", "grant kept", refresh_grant, 1'b1);
        refresh_req = 0;
        #1;
        chk("R8", "grant withdrawn", refresh_grant, 1'b0);
        step(1);
        chk("R8", "float not yet", bus_float, 1'b0);
        step(1);
        chk("R8", "float back", bus_float, 1'b1);
        chk("R8", "ack not yet", hold_ack, 1'b0);
        step(1);
        chk("R8", "ack back", hold_ack, 1'b1);
        go_idle();
    endtask

    task automatic t_simul();
        hold_req = 1; refresh_req = 1;
        #1;
        chk("R7", "grant immediate", refresh_grant, 1'b1);
        step(S + 6);
        chk("R7", "hold deferred ack", hold_ack, 1'b0);
        chk("R7", "hold deferred float", bus_float, 1'b0);
        refresh_req = 0;
        step(2);
        chk("R7", "float after refresh", bus_float, 1'b1);
        step(1);
        chk("R7", "ack after refresh", hold_ack, 1'b1);
        go_idle();
    endtask

    task automatic t_withdraw();
        cyc_active = 1; hold_req = 1;
        step(S + 2);
        hold_req = 0;
        step(S + 1);
        cyc_active = 0;
        step(3);
        chk("R9", "no float", bus_float, 1'b0);
        chk("R9", "no ack", hold_ack, 1'b0);
        go_idle();
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_cycle();
        t_lock();
        t_preempt();
        t_simul();
        t_withdraw();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule